// File: doc/BRIEF.md
# MMIO Window to Partition Mapper

This block sits in a PCIe host bridge and decides which isolation partition owns an incoming memory-mapped I/O address. It holds a small table of windows. Each window is a base/mask pair, so it is a power of two in size and aligned to that size. Each window also has a mode that says how addresses inside it turn into an 8-bit partition number. Some modes treat the whole window as one partition. Others cut the window into equal segments and pick the partition from the segment index: directly, through a per-segment lookup table, or as an offset from a programmed base.

Software fills the table through a simple write port, one field per write. A lookup request gives an address. One clock later the block returns a hit or miss flag and the partition number of the lowest-numbered enabled window that contains the address. There are two guards on the write port. A window's placement cannot move while the window is enabled. A configuration that would put an offset-mode window on a partition base that is not a multiple of its segment count is refused and flagged.

Top module: `mmio_pe_mapper`

## Requirements
- R1: After reset every entry is disabled and every lookup misses. An enabled entry matches an address when `((addr ^ base) & mask) == 0`.
- R2: Results are registered. `res_valid` is high in the cycle after a cycle with `lk_valid` high, and the result is for the address given in that cycle.
- R3: When no enabled entry matches, the result has `res_miss`=1, `res_hit`=0 and `res_pe`=0. Outside a result cycle, hit, miss and partition are all 0.
- R4: When several enabled entries match, the entry with the lowest index supplies the partition.
- R5: The control field (`wr_field`=2) takes the mode from `wr_data[2:0]`: 0 disabled, 1 segmented, 2 single partition, 3 remap, 4 base offset. Mode values 5 to 7 are refused.
- R6: Segmented mode cuts the window (size 2^t, where t is the number of trailing zero bits of the mask) into 256 segments. The segment index is `(addr & ~mask) >> (t-8)`, clamped to a shift of 0, and the partition equals that index.
- R7: Single-partition mode returns the entry's partition field (`wr_field`=3, `wr_data[7:0]`) for every address in the window.
- R8: Remap mode cuts the window into REMAP_SEGS segments. Each segment returns its own partition, written with `wr_field`=4, slot in `wr_data[8 +: log2 REMAP_SEGS]` and partition in `wr_data[7:0]`. Slots reset to 0.
- R9: Base-offset mode takes its segment count from `wr_data[5:4]` of the control write: 0 gives 8, 1 gives 64, 2 gives 128. The partition is the partition field plus the segment index.
- R10: A control or partition write is refused, with no field of it applied, when it would leave the entry in base-offset mode with count code 3 or with a partition base that is not a multiple of the segment count. `wr_reject` pulses in the cycle after a refused write.
- R11: A write takes effect at the clock edge that samples it. A lookup sampled at the same edge still sees the old table.
- R12: Writes to an entry's base (`wr_field`=0) or mask (`wr_field`=1) are ignored while that entry's mode is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_entry | input | log2(N_ENT) | Entry written |
| wr_field | input | 3 | Field select: 0 base, 1 mask, 2 control, 3 partition, 4 remap slot |
| wr_data | input | ADDR_W | Write data |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Address looked up |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | An enabled entry matched |
| res_miss | output | 1 | No enabled entry matched |
| res_pe | output | PE_W | Partition number, 0 on miss |
| wr_reject | output | 1 | Previous write was refused |

## Verification
The bench builds the block with its defaults: 32-bit addresses, 8-bit partitions, 16 entries and 16 remap segments per entry. These sizes give overlapping windows between entry 0 and a higher entry for the priority rule. They also let all three base-offset segment counts be reached on one 1 MB window, with a base of 0x40 that is aligned for 8 and 64 segments but not for 128. A mask of 0 would give a window the size of the whole address space, and 32 bits keeps that case within a 64-bit integer in the reference model.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [2:0] {
        M_OFF    = 3'd0,
        M_SEG    = 3'd1,
        M_SINGLE = 3'd2,
        M_REMAP  = 3'd3,
        M_OFFSET = 3'd4
    } mw_mode_e;

    typedef enum logic [2:0] {
        F_BASE  = 3'd0,
        F_MASK  = 3'd1,
        F_CTRL  = 3'd2,
        F_PE    = 3'd3,
        F_REMAP = 3'd4
    } mw_field_e;

    // log2 of the base-offset segment count for a count code; 0 for the illegal code
    function automatic int off_lg(input logic [1:0] code);
        case (code)
            2'd0:    return 3;
            2'd1:    return 6;
            2'd2:    return 7;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/mw_table.sv
module mw_table
    import mw_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PE_W      = 8,
    parameter int N_ENT     = 16,
    parameter int REMAP_SEGS = 16,
    localparam int EIDX_W   = $clog2(N_ENT),
    localparam int RSLOT_W  = $clog2(REMAP_SEGS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [EIDX_W-1:0]             wr_entry,
    input  logic [2:0]                    wr_field,
    input  logic [ADDR_W-1:0]             wr_data,
    output logic [ADDR_W-1:0]             base_q  [N_ENT],
    output logic [ADDR_W-1:0]             mask_q  [N_ENT],
    output mw_mode_e                      mode_q  [N_ENT],
    output logic [1:0]                    cnt_q   [N_ENT],
    output logic [PE_W-1:0]               pe_q    [N_ENT],
    output logic [REMAP_SEGS*PE_W-1:0]    remap_q [N_ENT],
    output logic                          wr_reject
);

    mw_mode_e          cur_mode, n_mode;
    logic [1:0]        n_cnt;
    logic [PE_W-1:0]   n_pe;
    logic              mode_ok, off_ok, legal, cfg_write;
    logic [RSLOT_W-1:0] slot;

    assign slot = wr_data[PE_W +: RSLOT_W];

    // Evaluate the configuration the entry would hold after this write
    always_comb begin
        cur_mode  = mode_q[wr_entry];
        n_mode    = cur_mode;
        n_cnt     = cnt_q[wr_entry];
        n_pe      = pe_q[wr_entry];
        mode_ok   = 1'b1;
        cfg_write = (wr_field == F_CTRL) || (wr_field == F_PE);
        if (wr_field == F_CTRL) begin
            n_mode  = mw_mode_e'(wr_data[2:0]);
            n_cnt   = wr_data[5:4];
            mode_ok = (wr_data[2:0] <= 3'd4);
        end
        if (wr_field == F_PE) begin
            n_pe = wr_data[PE_W-1:0];
        end
        off_ok = (n_mode != M_OFFSET) ||
                 ((n_cnt != 2'd3) && ((n_pe & PE_W'((1 << off_lg(n_cnt)) - 1)) == '0));
        legal  = mode_ok && off_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < N_ENT; e++) begin
                base_q[e]  <= '0;
                mask_q[e]  <= '0;
                mode_q[e]  <= M_OFF;
                cnt_q[e]   <= '0;
                pe_q[e]    <= '0;
                remap_q[e] <= '0;
            end
            wr_reject <= 1'b0;
        end else begin
            wr_reject <= wr_en && cfg_write && !legal;
            if (wr_en) begin
                case (wr_field)
                    F_BASE:  if (cur_mode == M_OFF) base_q[wr_entry] <= wr_data;
                    F_MASK:  if (cur_mode == M_OFF) mask_q[wr_entry] <= wr_data;
                    F_CTRL:  if (legal) begin
                                 mode_q[wr_entry] <= n_mode;
                                 cnt_q[wr_entry]  <= n_cnt;
                             end
                    F_PE:    if (legal) pe_q[wr_entry] <= n_pe;
                    F_REMAP: remap_q[wr_entry][int'(slot)*PE_W +: PE_W] <= wr_data[PE_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    for (genvar e = 0; e < N_ENT; e++) begin : g_chk
        // R12
        base_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[e] != M_OFF) |=> $stable(base_q[e]));
        // R12
        mask_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[e] != M_OFF) |=> $stable(mask_q[e]));
        // R10
        off_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[e] == M_OFFSET) |->
            ((cnt_q[e] != 2'd3) && ((pe_q[e] & PE_W'((1 << off_lg(cnt_q[e])) - 1)) == '0)));
        // R5
        mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[e] <= M_OFFSET));
    end

endmodule

// File: rtl/mw_entry_match.sv
module mw_entry_match
    import mw_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PE_W       = 8,
    parameter int REMAP_SEGS = 16,
    localparam int RSLOT_W   = $clog2(REMAP_SEGS)
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic [ADDR_W-1:0]          base,
    input  logic [ADDR_W-1:0]          mask,
    input  mw_mode_e                   mode,
    input  logic [1:0]                 cnt,
    input  logic [PE_W-1:0]            pe_cfg,
    input  logic [REMAP_SEGS*PE_W-1:0] remap_row,
    output logic                       hit,
    output logic [PE_W-1:0]            pe
);

    int                tz, lg, sh;
    logic [ADDR_W-1:0] offs, idx;

    always_comb begin
        // window size is 2^tz, tz = trailing zero count of the mask
        tz = ADDR_W;
        for (int i = ADDR_W - 1; i >= 0; i--) begin
            if (mask[i]) tz = i;
        end
        case (mode)
            M_SEG:    lg = PE_W;
            M_REMAP:  lg = RSLOT_W;
            M_OFFSET: lg = off_lg(cnt);
            default:  lg = 0;
        endcase
        sh   = (tz > lg) ? (tz - lg) : 0;
        offs = addr & ~mask;
        idx  = (offs >> sh) & ~({ADDR_W{1'b1}} << lg);
        hit  = (mode != M_OFF) && (((addr ^ base) & mask) == '0);
        case (mode)
            M_SEG:    pe = idx[PE_W-1:0];
            M_SINGLE: pe = pe_cfg;
            M_REMAP:  pe = remap_row[int'(idx[RSLOT_W-1:0])*PE_W +: PE_W];
            M_OFFSET: pe = pe_cfg + idx[PE_W-1:0];
            default:  pe = '0;
        endcase
    end

endmodule

// File: rtl/mw_prio_pick.sv
module mw_prio_pick #(
    parameter int PE_W  = 8,
    parameter int N_ENT = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_ENT-1:0]      hit_vec,
    input  logic [N_ENT*PE_W-1:0] pe_flat,
    output logic                  any_hit,
    output logic [PE_W-1:0]       pe_sel
);

    logic [N_ENT-1:0] grant;

    always_comb begin
        grant   = hit_vec & (~hit_vec + 1'b1);
        any_hit = |hit_vec;
        pe_sel  = '0;
        for (int e = 0; e < N_ENT; e++) begin
            if (grant[e]) pe_sel = pe_sel | pe_flat[e*PE_W +: PE_W];
        end
    end

    for (genvar e = 0; e < N_ENT; e++) begin : g_chk
        localparam logic [N_ENT-1:0] LOWER = N_ENT'((64'd1 << e) - 64'd1);
        // R4
        lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grant[e] |-> (hit_vec[e] && ((hit_vec & LOWER) == '0)));
    end

endmodule

// File: rtl/mmio_pe_mapper.sv
module mmio_pe_mapper
    import mw_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PE_W       = 8,
    parameter int N_ENT      = 16,
    parameter int REMAP_SEGS = 16,
    localparam int EIDX_W    = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [EIDX_W-1:0] wr_entry,
    input  logic [2:0]        wr_field,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_miss,
    output logic [PE_W-1:0]   res_pe,
    output logic              wr_reject
);

    logic [ADDR_W-1:0]          base_q  [N_ENT];
    logic [ADDR_W-1:0]          mask_q  [N_ENT];
    mw_mode_e                   mode_q  [N_ENT];
    logic [1:0]                 cnt_q   [N_ENT];
    logic [PE_W-1:0]            pe_q    [N_ENT];
    logic [REMAP_SEGS*PE_W-1:0] remap_q [N_ENT];
    logic [N_ENT-1:0]           hit_vec;
    logic [N_ENT*PE_W-1:0]      pe_flat;
    logic                       any_hit;
    logic [PE_W-1:0]            pe_sel;

    mw_table #(.ADDR_W(ADDR_W), .PE_W(PE_W), .N_ENT(N_ENT), .REMAP_SEGS(REMAP_SEGS)) u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_entry(wr_entry),
        .wr_field(wr_field), .wr_data(wr_data),
        .base_q(base_q), .mask_q(mask_q), .mode_q(mode_q), .cnt_q(cnt_q),
        .pe_q(pe_q), .remap_q(remap_q), .wr_reject(wr_reject)
    );

    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
        mw_entry_match #(.ADDR_W(ADDR_W), .PE_W(PE_W), .REMAP_SEGS(REMAP_SEGS)) u_match (
            .addr(lk_addr), .base(base_q[e]), .mask(mask_q[e]), .mode(mode_q[e]),
            .cnt(cnt_q[e]), .pe_cfg(pe_q[e]), .remap_row(remap_q[e]),
            .hit(hit_vec[e]), .pe(pe_flat[e*PE_W +: PE_W])
        );
    end

    mw_prio_pick #(.PE_W(PE_W), .N_ENT(N_ENT)) u_pick (
        .clk(clk), .rst_n(rst_n), .hit_vec(hit_vec), .pe_flat(pe_flat),
        .any_hit(any_hit), .pe_sel(pe_sel)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_miss  <= 1'b0;
            res_pe    <= '0;
        end else begin
            res_valid <= lk_valid;
            res_hit   <= lk_valid && any_hit;
            res_miss  <= lk_valid && !any_hit;
            res_pe    <= (lk_valid && any_hit) ? pe_sel : '0;
        end
    end

    // R2
    res_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);
    // R3
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_miss |-> (!res_hit && res_pe == '0 && res_valid));
    // R10
    reject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reject |-> $past(wr_en));

endmodule

// File: tb/tb_mmio_pe_mapper.sv
module tb_mmio_pe_mapper;

    localparam int ADDR_W = 32;
    localparam int PE_W   = 8;
    localparam int N_ENT  = 16;
    localparam int RSEGS  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [3:0]        wr_entry = '0;
    logic [2:0]        wr_field = '0;
    logic [ADDR_W-1:0] wr_data = '0;
    logic              lk_valid = 1'b0;
    logic [ADDR_W-1:0] lk_addr = '0;
    logic              res_valid, res_hit, res_miss, wr_reject;
    logic [PE_W-1:0]   res_pe;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // reference model state
    longint m_base [N_ENT];
    longint m_mask [N_ENT];
    int     m_mode [N_ENT];
    int     m_cnt  [N_ENT];
    int     m_pe   [N_ENT];
    int     m_rm   [N_ENT][RSEGS];
    int     e_valid, e_hit, e_miss, e_pe, e_rej;

    always #2 clk = ~clk;

    mmio_pe_mapper #(.ADDR_W(ADDR_W), .PE_W(PE_W), .N_ENT(N_ENT), .REMAP_SEGS(RSEGS)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_entry(wr_entry), .wr_field(wr_field),
        .wr_data(wr_data), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
        .res_pe(res_pe), .wr_reject(wr_reject)
    );

    function automatic int seg_count(int mode, int code);
        if (mode == 1) return 256;
        if (mode == 3) return RSEGS;
        if (mode == 4) return (code == 0) ? 8 : (code == 1) ? 64 : (code == 2) ? 128 : 1;
        return 1;
    endfunction

    task automatic model_lookup(input longint a, output int hit, output int pe);
        hit = 0; pe = 0;
        for (int e = 0; e < N_ENT; e++) begin
            if (hit == 0 && m_mode[e] != 0 && (((a ^ m_base[e]) & m_mask[e]) == 0)) begin
                longint win = 1;
                longint segsz, idx;
                for (int b = 0; b < ADDR_W; b++) begin
                    if (m_mask[e][b]) break;
                    win = win * 2;
                end
                segsz = win / seg_count(m_mode[e], m_cnt[e]);
                if (segsz == 0) segsz = 1;
                idx = (a & ~m_mask[e] & 64'hFFFF_FFFF) / segsz;
                hit = 1;
                case (m_mode[e])
                    1: pe = int'(idx);
                    2: pe = m_pe[e];
                    3: pe = m_rm[e][int'(idx)];
                    default: pe = (m_pe[e] + int'(idx)) % 256;
                endcase
            end
        end
    endtask

    task automatic model_write();
        int e = int'(wr_entry);
        int d = int'(wr_data);
        e_rej = 0;
        if (!wr_en) return;
        case (wr_field)
            3'd0: if (m_mode[e] == 0) m_base[e] = longint'(wr_data);
            3'd1: if (m_mode[e] == 0) m_mask[e] = longint'(wr_data);
            3'd2: begin
                int nm = d & 7;
                int nc = (d >> 4) & 3;
                if (nm > 4 || (nm == 4 && (nc == 3 || (m_pe[e] % seg_count(4, nc)) != 0)))
                    e_rej = 1;
                else begin m_mode[e] = nm; m_cnt[e] = nc; end
            end
            3'd3: begin
                int np = d & 255;
                if (m_mode[e] == 4 && (np % seg_count(4, m_cnt[e])) != 0) e_rej = 1;
                else m_pe[e] = np;
            end
            3'd4: m_rm[e][(d >> 8) & (RSEGS - 1)] = d & 255;
            default: ;
        endcase
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one clock: expectations from the model at the edge, comparison at the falling edge
    task automatic cyc();
        int h, p;
        @(posedge clk);
        model_lookup(longint'(lk_addr), h, p);
        e_valid = int'(lk_valid);
        e_hit   = lk_valid ? h : 0;
        e_miss  = lk_valid ? (1 - h) : 0;
        e_pe    = (lk_valid && h == 1) ? p : 0;
        model_write();
        @(negedge clk);
        checks++;
        if (int'(res_valid) != e_valid || int'(res_hit) != e_hit || int'(res_miss) != e_miss ||
            int'(res_pe) != e_pe || int'(wr_reject) != e_rej) begin
            errors++;
            $display("FAIL %s model: actual v=%0d h=%0d m=%0d pe=%0h rej=%0d expected v=%0d h=%0d m=%0d pe=%0h rej=%0d",
                     cur_req, res_valid, res_hit, res_miss, res_pe, wr_reject,
                     e_valid, e_hit, e_miss, e_pe, e_rej);
        end
        wr_en = 1'b0;
        lk_valid = 1'b0;
    endtask

    task automatic wr(input int e, input int f, input logic [31:0] d);
        wr_en = 1'b1; wr_entry = 4'(e); wr_field = 3'(f); wr_data = d;
        cyc();
    endtask

    task automatic lk(input string req, input logic [31:0] a, input int exp_hit, input int exp_pe);
        cur_req = req;
        lk_valid = 1'b1; lk_addr = a;
        cyc();
        check(req, "hit", int'(res_hit), exp_hit);
        check(req, "pe", int'(res_pe), exp_pe);
    endtask

    initial begin
        #(4 * 190000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int e = 0; e < N_ENT; e++) begin
            m_base[e] = 0; m_mask[e] = 0; m_mode[e] = 0; m_cnt[e] = 0; m_pe[e] = 0;
            for (int s = 0; s < RSEGS; s++) m_rm[e][s] = 0;
        end
        repeat (3) @(negedge clk);
        check("R1", "reset res_valid", int'(res_valid), 0);
        check("R1", "reset wr_reject", int'(wr_reject), 0);
        rst_n = 1'b1;
        @(negedge clk);

        lk("R1", 32'h4230_0000, 0, 0);
        check("R3", "miss flag", int'(res_miss), 1);
        check("R2", "valid", int'(res_valid), 1);
        cyc();
        check("R2", "valid drop", int'(res_valid), 0);

        // R6 segmented entry 3: 256 MB window, 1 MB segments
        cur_req = "R6";
        wr(3, 0, 32'h4000_0000); wr(3, 1, 32'hF000_0000); wr(3, 2, 32'h1);
        lk("R6", 32'h4230_0000, 1, 8'h23);
        lk("R6", 32'h4FF0_0000, 1, 8'hFF);

        // R7 single partition entry 1
        cur_req = "R7";
        wr(1, 0, 32'h8000_0000); wr(1, 1, 32'hFFFF_0000); wr(1, 3, 32'h77); wr(1, 2, 32'h2);
        lk("R7", 32'h8000_ABCD, 1, 8'h77);
        lk("R3", 32'h8001_0000, 0, 0);

        // R4 entry 0 overlaps the first megabyte of entry 3
        cur_req = "R4";
        wr(0, 0, 32'h4000_0000); wr(0, 1, 32'hFFF0_0000); wr(0, 3, 32'h11); wr(0, 2, 32'h2);
        lk("R4", 32'h4000_1234, 1, 8'h11);
        lk("R4", 32'h4230_0000, 1, 8'h23);

        // R8 remap entry 5: 16 MB window, 16 slots
        cur_req = "R8";
        wr(5, 0, 32'h1000_0000); wr(5, 1, 32'hFF00_0000); wr(5, 4, 32'h0000_02A5); wr(5, 2, 32'h3);
        lk("R8", 32'h1020_0000, 1, 8'hA5);
        lk("R8", 32'h1000_0004, 1, 8'h00);

        // R9 base offset entry 7: 1 MB window
        cur_req = "R9";
        wr(7, 0, 32'h2000_0000); wr(7, 1, 32'hFFF0_0000); wr(7, 3, 32'h40); wr(7, 2, 32'h04);
        lk("R9", 32'h2006_0000, 1, 8'h43);
        lk("R9", 32'h200F_FFFF, 1, 8'h47);

        // R10 misaligned base, count 128 and count code 3 refused
        cur_req = "R10";
        wr(7, 3, 32'h44);
        check("R10", "reject pe", int'(wr_reject), 1);
        lk("R10", 32'h2006_0000, 1, 8'h43);
        wr(7, 2, 32'h14);
        check("R10", "accept 64", int'(wr_reject), 0);
        lk("R9", 32'h2006_0000, 1, 8'h58);
        wr(7, 2, 32'h24);
        check("R10", "reject 128", int'(wr_reject), 1);
        wr(7, 2, 32'h34);
        check("R10", "reject code3", int'(wr_reject), 1);
        lk("R10", 32'h2006_0000, 1, 8'h58);

        // R5 undefined mode refused
        cur_req = "R5";
        wr(1, 2, 32'h5);
        check("R5", "reject mode5", int'(wr_reject), 1);
        lk("R5", 32'h8000_0010, 1, 8'h77);

        // R12 base locked while enabled
        cur_req = "R12";
        wr(1, 0, 32'h9000_0000);
        lk("R12", 32'h8000_0010, 1, 8'h77);
        lk("R12", 32'h9000_0010, 0, 0);
        wr(1, 1, 32'hFF00_0000);
        lk("R12", 32'h8001_0000, 0, 0);
        wr(1, 2, 32'h0);
        lk("R5", 32'h8000_0010, 0, 0);
        wr(1, 0, 32'h9000_0000); wr(1, 2, 32'h2);
        lk("R12", 32'h9000_0010, 1, 8'h77);

        // R11 write and lookup at the same edge
        cur_req = "R11";
        wr_en = 1'b1; wr_entry = 4'd1; wr_field = 3'd2; wr_data = 32'h0;
        lk("R11", 32'h9000_0010, 1, 8'h77);
        lk("R11", 32'h9000_0010, 0, 0);

        // mixed traffic against the model
        cur_req = "R1";
        for (int i = 0; i < 3000; i++) begin
            int k = $urandom_range(0, 5);
            logic [31:0] bases [6] = '{32'h4000_0000, 32'h1000_0000, 32'h2000_0000,
                                       32'h9000_0000, 32'h8000_0000, 32'h0000_0000};
            if ($urandom_range(0, 7) == 0) begin
                wr_en = 1'b1;
                wr_entry = ($urandom_range(0, 1) == 0) ? 4'd5 : 4'd7;
                wr_field = ($urandom_range(0, 1) == 0) ? 3'd4 : 3'd3;
                wr_data = {16'h0, 4'h0, 4'($urandom_range(0, 15)), 8'($urandom_range(0, 255))};
            end
            lk_valid = ($urandom_range(0, 3) != 0);
            lk_addr = bases[k] | (32'($urandom()) & 32'h0FFF_FFFF);
            cyc();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule